// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This unit decides whether a conditional branch is taken. It keeps a small register of ALU status: zero (Z), negative (N), carry (C), overflow (V) and an exact-fraction indicator (E). The register is loaded only on a cycle in which the ALU raises its flags-valid strobe. A 5-bit condition field from the branch instruction chooses a test mode, a flag pair and two mask bits. The unit combines that field with the stored status to give a one-bit take decision. The 10-bit branch target is passed straight through.

The decision is combinational. It follows the stored flags and the condition field, so a sequencer can present a branch instruction and use the answer in the same cycle.

Condition field layout: bits [4:3] are the mode, bit [2] is the pair select, bit [1] is the first-status mask and bit [0] is the second-status mask.

Top module: `brcond_eval`

## Requirements
- R1: After reset, all five stored flags (Z, N, C, V, E) are 0.
- R2: The stored flags take the ALU inputs at a rising clock edge only when flagsValid is 1. With flagsValid at 0, the ALU inputs have no effect on the stored flags or on the decision.
- R3: targetOut always equals targetIn.
- R4: Pair select bit [2] = 0 makes N the first status and V the second. Bit [2] = 1 makes C the first status and Z the second.
- R5: Mode 01 with at least one mask bit set takes the branch only if each masked status is 1. Mask bit [1] gates the first status and mask bit [0] gates the second.
- R6: Mode 10 works like R5, except that both statuses are inverted before the test.
- R7: Mode 01 with both mask bits 0 takes the branch when Z AND E holds if bit [2] = 0. It takes the branch when Z AND E does not hold if bit [2] = 1.
- R8: Mode 10 with both mask bits 0 never takes the branch.
- R9: Mode 11 with bit [2] = 0 takes the branch when ((N xor V) or (Z and mask[0])) differs from mask[1].
- R10: Mode 11 with bit [2] = 1 and mask[1] = 0 takes the branch when (C and not Z) differs from mask[0].
- R11: Mode 11 with bit [2] = 1 and mask[1] = 1 takes the branch when E differs from mask[0].
- R12: Mode 00 never takes the branch.
- R13: takeBranch follows a change of condField in the same cycle, with no clock edge between the change and the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flagsValid | input | 1 | ALU strobe: capture the status inputs |
| aluZero | input | 1 | ALU zero status |
| aluNeg | input | 1 | ALU negative status |
| aluCarry | input | 1 | ALU carry status |
| aluOvf | input | 1 | ALU overflow status |
| aluExact | input | 1 | ALU exact-fraction status |
| condField | input | 5 | Condition: mode[4:3], select[2], mask1[1], mask0[0] |
| targetIn | input | 10 | Branch target from the instruction |
| takeBranch | output | 1 | 1 when the branch is taken |
| targetOut | output | 10 | Pass-through branch target |

## Verification
The bench targets the following corner cases:

- **Both masks clear in modes 01 and 10.** A design that applied the AND test here with nothing to AND would always branch. A design that let the zero-and-exact test leak into mode 10 would branch in that mode.
- **Flag register during reset and on strobe-free cycles.** A register that loaded without the strobe would show the new flags in the mode 11 exact test on the next cycle.
- **Mode 11 sub-cases.** A swapped pair select, or a dropped (Z and mask[0]) term in the signed test, makes the decision disagree with the bench model on random flag patterns.
- **Same-cycle response.** A registered decision would lag a condition change by one cycle.

// File: rtl/brcond_pkg.sv
package brcond_pkg;
  localparam int COND_W = 5;

  typedef struct packed {
    logic zero;
    logic neg;
    logic carry;
    logic ovf;
    logic exact;
  } statusT;

  typedef struct packed {
    logic [1:0] mode;
    logic       sel;
    logic       mask1;
    logic       mask0;
  } condT;

  // strobes from the control decoder to the datapath
  typedef struct packed {
    logic loadFlags;
    logic modeAnd;
    logic modeInv;
    logic modeCmp;
    logic pairSel;
    logic gateFirst;
    logic gateSecond;
  } ctrlT;
endpackage

// File: rtl/brcond_ctrl.sv
module brcond_ctrl
  import brcond_pkg::*;
(
  input  logic flagsValid,
  input  condT cond,
  output ctrlT strobes
);
  always_comb begin
    strobes.loadFlags  = flagsValid;
    strobes.modeAnd    = (cond.mode == 2'b01);
    strobes.modeInv    = (cond.mode == 2'b10);
    strobes.modeCmp    = (cond.mode == 2'b11);
    strobes.pairSel    = cond.sel;
    strobes.gateFirst  = cond.mask1;
    strobes.gateSecond = cond.mask0;
  end
endmodule

// File: rtl/brcond_datapath.sv
module brcond_datapath
  import brcond_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  statusT aluStatus,
  input  ctrlT   strobes,
  output statusT heldFlags,
  output logic   takeBranch
);
  statusT flagReg;

  always_ff @(posedge clk) begin
    if (!rst_n)                 flagReg <= '0;
    else if (strobes.loadFlags) flagReg <= aluStatus;
  end

  assign heldFlags = flagReg;

  logic firstStat, secondStat, firstEff, secondEff, maskAny;
  logic andHit, specialHit, cmpSigned, cmpUnsigned, cmpExact, cmpHit, zeExact;

  always_comb begin
    firstStat  = strobes.pairSel ? flagReg.carry : flagReg.neg;
    secondStat = strobes.pairSel ? flagReg.zero  : flagReg.ovf;
    firstEff   = firstStat  ^ strobes.modeInv;
    secondEff  = secondStat ^ strobes.modeInv;
    maskAny    = strobes.gateFirst | strobes.gateSecond;
    andHit     = (strobes.modeAnd | strobes.modeInv) & maskAny
               & (~strobes.gateFirst  | firstEff)
               & (~strobes.gateSecond | secondEff);
    zeExact    = flagReg.zero & flagReg.exact;
    specialHit = strobes.modeAnd & ~maskAny & (strobes.pairSel ? ~zeExact : zeExact);
    cmpSigned  = ((flagReg.neg ^ flagReg.ovf) | (flagReg.zero & strobes.gateSecond))
                 != strobes.gateFirst;
    cmpUnsigned = (flagReg.carry & ~flagReg.zero) != strobes.gateSecond;
    cmpExact    = flagReg.exact != strobes.gateSecond;
    cmpHit     = strobes.modeCmp &
                 (strobes.pairSel ? (strobes.gateFirst ? cmpExact : cmpUnsigned) : cmpSigned);
    takeBranch = andHit | specialHit | cmpHit;
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flagReg == '0));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.loadFlags |=> $stable(flagReg));
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadFlags |=> (flagReg == $past(aluStatus)));
  a_r12_mode0_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.modeAnd | strobes.modeInv | strobes.modeCmp) |-> !takeBranch);
  a_r8_inv_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.modeInv && !strobes.gateFirst && !strobes.gateSecond) |-> !takeBranch);
endmodule

// File: rtl/brcond_eval.sv
module brcond_eval
  import brcond_pkg::*;
#(
  parameter int TARGET_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flagsValid,
  input  logic                aluZero,
  input  logic                aluNeg,
  input  logic                aluCarry,
  input  logic                aluOvf,
  input  logic                aluExact,
  input  logic [COND_W-1:0]   condField,
  input  logic [TARGET_W-1:0] targetIn,
  output logic                takeBranch,
  output logic [TARGET_W-1:0] targetOut
);
  condT   cond;
  statusT aluStatus;
  statusT heldFlags;
  ctrlT   strobes;

  assign cond      = condT'(condField);
  assign aluStatus = '{zero: aluZero, neg: aluNeg, carry: aluCarry, ovf: aluOvf, exact: aluExact};
  assign targetOut = targetIn;

  brcond_ctrl u_ctrl (
    .flagsValid (flagsValid),
    .cond       (cond),
    .strobes    (strobes)
  );

  brcond_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .aluStatus  (aluStatus),
    .strobes    (strobes),
    .heldFlags  (heldFlags),
    .takeBranch (takeBranch)
  );

  a_r11_exact_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (cond.mode == 2'b11 && cond.sel && cond.mask1) |-> (takeBranch == (heldFlags.exact != cond.mask0)));
  a_r10_unsigned_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (cond.mode == 2'b11 && cond.sel && !cond.mask1)
      |-> (takeBranch == ((heldFlags.carry & ~heldFlags.zero) != cond.mask0)));
endmodule

// File: tb/brcond_eval_test.sv
`timescale 1ns/1ps
module brcond_eval_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, flagsValid, aluZero, aluNeg, aluCarry, aluOvf, aluExact;
  logic [4:0] condField;
  logic [9:0] targetIn, targetOut;
  logic       takeBranch;

  brcond_eval uut (
    .clk(clk), .rst_n(rst_n), .flagsValid(flagsValid),
    .aluZero(aluZero), .aluNeg(aluNeg), .aluCarry(aluCarry), .aluOvf(aluOvf), .aluExact(aluExact),
    .condField(condField), .targetIn(targetIn), .takeBranch(takeBranch), .targetOut(targetOut)
  );

  int runs = 0;
  int fails = 0;
  logic mz = 0, mn = 0, mc = 0, mv = 0, me = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cond=%b actual=%0h expected=%0h", tag, condField, act, exp);
    end
  endtask

  function automatic logic expTake(logic [4:0] c);
    logic s1, s2, m1, m0, sel;
    sel = c[2]; m1 = c[1]; m0 = c[0];
    s1 = sel ? mc : mn;
    s2 = sel ? mz : mv;
    case (c[4:3])
      2'b00: return 1'b0;
      2'b01: if (!m1 && !m0) return sel ? !(mz && me) : (mz && me);
             else return (!m1 || s1) && (!m0 || s2);
      2'b10: if (!m1 && !m0) return 1'b0;
             else return (!m1 || !s1) && (!m0 || !s2);
      default: if (!sel) return (((mn ^ mv) || (mz && m0)) != m1);
               else if (!m1) return ((mc && !mz) != m0);
               else return (me != m0);
    endcase
  endfunction

  function automatic string tagOf(logic [4:0] c);
    case (c[4:3])
      2'b00: return "R12";
      2'b01: return (c[1:0] == 0) ? "R7" : (c[2] ? "R5/R4 sel1" : "R5");
      2'b10: return (c[1:0] == 0) ? "R8" : "R6";
      default: return !c[2] ? "R9" : (!c[1] ? "R10" : "R11");
    endcase
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 0; flagsValid = 1; {aluZero, aluNeg, aluCarry, aluOvf, aluExact} = '1;
    condField = 5'b11_1_1_1; targetIn = 10'h155;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1; flagsValid = 0;
    #1;
    // R1: all flags zero -> exact test with mask0=1 differs
    chk("R1", takeBranch, 1'b1);
    condField = 5'b11_1_1_0; #1 chk("R1", takeBranch, 1'b0);
    condField = 5'b11_1_0_1; #1 chk("R1", takeBranch, 1'b1);
    condField = 5'b01_1_0_0; #1 chk("R1", takeBranch, 1'b1);
    chk("R3", targetOut, 10'h155);
    // R2: no strobe, ALU inputs ignored
    condField = 5'b11_1_1_1;
    @(posedge clk); #1 chk("R2", takeBranch, 1'b1);
    @(posedge clk); #1 chk("R2", takeBranch, 1'b1);
    @(negedge clk) flagsValid = 1;
    @(posedge clk); mz = 1; mn = 1; mc = 1; mv = 1; me = 1;
    #1 chk("R2", takeBranch, 1'b0);
    // R7 corner: Z and E both set
    condField = 5'b01_0_0_0; #1 chk("R7", takeBranch, 1'b1);
    condField = 5'b10_0_0_0; #1 chk("R8", takeBranch, 1'b0);
    condField = 5'b10_1_1_1; #1 chk("R6", takeBranch, 1'b0);
    condField = 5'b00_1_1_1; #1 chk("R12", takeBranch, 1'b0);

    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      flagsValid = ($urandom_range(0, 3) != 0);
      {aluZero, aluNeg, aluCarry, aluOvf, aluExact} = 5'($urandom);
      condField = 5'($urandom);
      targetIn = 10'($urandom);
      @(posedge clk);
      if (flagsValid) {mz, mn, mc, mv, me} = {aluZero, aluNeg, aluCarry, aluOvf, aluExact};
      #1;
      chk(tagOf(condField), takeBranch, expTake(condField));
      chk("R3", targetOut, targetIn);
      condField = 5'($urandom);
      #1 chk("R13", takeBranch, expTake(condField));
    end

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule